// File: doc/BRIEF.md
# Global-history branch direction predictor

This block predicts the direction of conditional branches from the recent history of all branch outcomes. A single shift register holds the last few directions. It indexes a table of 2-bit saturating counters, and the top bit of the selected counter is the prediction. When a prediction is made, the predicted direction is shifted into the history at once, so the next prediction already sees it. The counters themselves are trained only when the branch resolves.

Each prediction hands back the history value that was used to make it. The front end carries this snapshot along with the branch. At resolution the snapshot comes back with the actual direction and a mispredict flag. The snapshot selects the counter to train. On a mispredict, the snapshot, with the correct direction appended, becomes the new history.

When a prediction and a resolve arrive in the same cycle, the resolve takes priority. A repair changes the history that the new prediction uses. A counter update to the entry being read is passed straight through to the prediction.

Top module: `glob_dir_pred`

## Requirements
- R1: After reset the history is all zeros and every counter holds 01 (weakly not-taken), so the first prediction is not-taken with snapshot 0.
- R2: The prediction is bit 1 of the selected counter: counter values 00 and 01 predict not-taken (0), and 10 and 11 predict taken (1).
- R3: When a prediction is requested, the next history is the current history shifted left by one, with the predicted bit entering at bit 0 and the oldest bit dropped. `pred_hist_o` shows the history used by the current prediction.
- R4: A resolve adds one to the counter at `res_hist_i` when the branch was taken and subtracts one when it was not. The counter saturates at 11 and at 00.
- R5: A resolve without a mispredict leaves the history unchanged.
- R6: A mispredicting resolve sets the history to `{res_hist_i[HIST_W-2:0], res_taken_i}`.
- R7: When a prediction request and a mispredicting resolve occur in the same cycle, the prediction uses the repaired history, and the predicted bit is shifted into the repaired history.
- R8: When a resolve updates the same counter that a same-cycle prediction reads, the prediction uses the updated counter value.
- R9: With no request and no resolve, the history and all counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | Prediction request; commits the speculative history shift |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | HIST_W | History used by this prediction (snapshot) |
| res_valid_i | input | 1 | Resolve strobe |
| res_hist_i | input | HIST_W | Snapshot that was returned with the resolving branch |
| res_taken_i | input | 1 | Actual direction, 1 = taken |
| res_mispred_i | input | 1 | The branch was mispredicted |

## Verification
The bench drives counters to both saturation limits, and checks that the prediction stays at the limit rather than wrapping. A design that wraps would flip its prediction after a long run of one direction. It also issues a prediction in the same cycle as a mispredicting resolve. A design that gives the old history priority would return a stale snapshot and lose the correct outcome from the history. A same-cycle resolve to the entry being read is checked as well: a design without the pass-through predicts from the counter value one update behind. Finally, correctly predicted resolves are checked to leave the speculative history alone, because a wrong repair there would erase younger predictions.

// File: rtl/glob_dir_pred_pkg.sv
package glob_dir_pred_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/gdp_hist_reg.sv
module gdp_hist_reg #(
  parameter int HIST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spec_en_i,
  input  logic              spec_bit_i,
  input  logic              fix_en_i,
  input  logic [HIST_W-1:0] fix_hist_i,
  input  logic              fix_bit_i,
  output logic [HIST_W-1:0] eff_hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d;

  // repair overrides the stored history in the same cycle
  always_comb begin
    eff_hist_o = fix_en_i ? {fix_hist_i[HIST_W-2:0], fix_bit_i} : hist_q;
    hist_d     = hist_q;
    if (spec_en_i)     hist_d = {eff_hist_o[HIST_W-2:0], spec_bit_i};
    else if (fix_en_i) hist_d = eff_hist_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
endmodule

// File: rtl/gdp_pattern_table.sv
module gdp_pattern_table
  import glob_dir_pred_pkg::*;
#(
  parameter int HIST_W = 3,
  localparam int DEPTH = 1 << HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] rd_idx_i,
  output ctr_t              rd_ctr_o
);
  ctr_t ctr_q [DEPTH];
  ctr_t upd_val;

  assign upd_val = ctr_step(ctr_q[upd_idx_i], upd_taken_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                        ctr_q[i] <= CTR_WEAK_NT;
      else if (upd_en_i && upd_idx_i == HIST_W'(i))       ctr_q[i] <= upd_val;
  end

  // pass the in-flight update through to a same-entry read
  assign rd_ctr_o = (upd_en_i && upd_idx_i == rd_idx_i) ? upd_val : ctr_q[rd_idx_i];
endmodule

// File: rtl/glob_dir_pred.sv
module glob_dir_pred
  import glob_dir_pred_pkg::*;
#(
  parameter int HIST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_req_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              res_valid_i,
  input  logic [HIST_W-1:0] res_hist_i,
  input  logic              res_taken_i,
  input  logic              res_mispred_i
);
  logic repair;
  ctr_t sel_ctr;

  assign repair       = res_valid_i && res_mispred_i;
  assign pred_taken_o = sel_ctr[1];

  gdp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .spec_en_i  (pred_req_i),
    .spec_bit_i (pred_taken_o),
    .fix_en_i   (repair),
    .fix_hist_i (res_hist_i),
    .fix_bit_i  (res_taken_i),
    .eff_hist_o (pred_hist_o)
  );

  gdp_pattern_table #(.HIST_W(HIST_W)) u_pht (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_en_i    (res_valid_i),
    .upd_idx_i   (res_hist_i),
    .upd_taken_i (res_taken_i),
    .rd_idx_i    (pred_hist_o),
    .rd_ctr_o    (sel_ctr)
  );
endmodule

// File: rtl/glob_dir_pred_chk.sv
module glob_dir_pred_chk #(
  parameter int HIST_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pred_req_i,
  input logic              pred_taken_o,
  input logic [HIST_W-1:0] pred_hist_o,
  input logic              res_valid_i,
  input logic [HIST_W-1:0] res_hist_i,
  input logic              res_taken_i,
  input logic              res_mispred_i
);
  logic past_ok;
  logic rep;
  assign rep = res_valid_i && res_mispred_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  AST_SPEC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(pred_req_i) && !rep |->
      pred_hist_o == {$past(pred_hist_o[HIST_W-2:0]), $past(pred_taken_o)}); // R3

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(pred_req_i) && !$past(rep) && !rep |->
      pred_hist_o == $past(pred_hist_o)); // R5

  AST_REPAIR_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep |-> pred_hist_o == {res_hist_i[HIST_W-2:0], res_taken_i}); // R7

  AST_REPAIR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(rep && !pred_req_i) && !rep |->
      pred_hist_o == $past({res_hist_i[HIST_W-2:0], res_taken_i})); // R6

  AST_PRED_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(pred_taken_o)); // R2
endmodule

bind glob_dir_pred glob_dir_pred_chk #(.HIST_W(HIST_W)) u_chk (.*);

// File: tb/sim_glob_dir_pred.sv
module sim_glob_dir_pred;
  localparam int  HW    = 3;
  localparam time CLK_P = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pred_req_i = 1'b0;
  logic          pred_taken_o;
  logic [HW-1:0] pred_hist_o;
  logic          res_valid_i = 1'b0;
  logic [HW-1:0] res_hist_i = '0;
  logic          res_taken_i = 1'b0;
  logic          res_mispred_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  logic [1:0]    m_pht [1<<HW];
  logic [HW-1:0] m_hist;

  always #(CLK_P/2) clk_i = ~clk_i;

  glob_dir_pred #(.HIST_W(HW)) u0 (.*);

  function automatic logic [1:0] step(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare combinational outputs, advance model
  task automatic cycle(string tag, logic rq, logic rv, logic [HW-1:0] rh, logic rt, logic rm);
    logic          rep;
    logic [HW-1:0] eh;
    logic [1:0]    c;
    @(negedge clk_i);
    pred_req_i = rq; res_valid_i = rv; res_hist_i = rh; res_taken_i = rt; res_mispred_i = rm;
    #1;
    rep = rv && rm;
    eh  = rep ? {rh[HW-2:0], rt} : m_hist;
    c   = (rv && rh == eh) ? step(m_pht[rh], rt) : m_pht[eh];
    check({tag, " hist"}, int'(pred_hist_o), int'(eh));
    check({tag, " pred"}, int'(pred_taken_o), int'(c[1]));
    if (rv) m_pht[rh] = step(m_pht[rh], rt);
    if (rq) m_hist = {eh[HW-2:0], c[1]};
    else if (rep) m_hist = eh;
    @(posedge clk_i);
  endtask

  task automatic idle(string tag);
    cycle(tag, 1'b0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1 reset hist", int'(pred_hist_o), 0);
    check("R1 reset pred", int'(pred_taken_o), 0);
    idle("R1");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 4; i++) cycle("R4 up", 1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
    idle("R4 top");           // counter 0 at 11, predicts taken (R2)
    cycle("R4 dn1", 1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
    idle("R2 still taken");   // 10
    for (int i = 0; i < 4; i++) cycle("R4 down", 1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
    cycle("R4 up1", 1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
    idle("R2 floor");         // 01, not-taken
  endtask

  task automatic t_shift;
    for (int i = 0; i < 5; i++) cycle("R3 shift", 1'b1, 1'b0, '0, 1'b0, 1'b0);
    cycle("R6 repair", 1'b0, 1'b1, 3'd3, 1'b1, 1'b1);
    idle("R6 kept");
    for (int i = 0; i < 3; i++) cycle("R3 after", 1'b1, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_no_mispred;
    cycle("R5 res", 1'b0, 1'b1, 3'd6, 1'b1, 1'b0);
    idle("R5 held");
    cycle("R5 res2", 1'b0, 1'b1, 3'd2, 1'b0, 1'b0);
    idle("R9 idle");
    idle("R9 idle2");
  endtask

  task automatic t_collide;
    cycle("R7 prime", 1'b0, 1'b1, 3'd2, 1'b1, 1'b0);
    cycle("R7 prime2", 1'b0, 1'b1, 3'd5, 1'b1, 1'b0);
    cycle("R7 same", 1'b1, 1'b1, 3'd2, 1'b1, 1'b1);
    idle("R7 after");
    cycle("R7 same nt", 1'b1, 1'b1, 3'd7, 1'b0, 1'b1);
    idle("R7 after2");
  endtask

  task automatic t_bypass;
    logic [HW-1:0] h;
    h = pred_hist_o;
    cycle("R8 byp", 1'b1, 1'b1, h, 1'b1, 1'b0);
    h = pred_hist_o;
    cycle("R8 byp2", 1'b1, 1'b1, h, 1'b1, 1'b0);
    h = pred_hist_o;
    cycle("R8 byp3", 1'b1, 1'b1, h, 1'b0, 1'b0);
    idle("R8 end");
  endtask

  initial begin
    for (int i = 0; i < (1<<HW); i++) m_pht[i] = 2'b01;
    m_hist = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_saturate();
    t_shift();
    t_no_mispred();
    t_collide();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule